// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

The dispatcher turns single writes of a command word into actions on individual processor cores. Each word names a target core, an operation and a six-bit vector. There are four operations. An interrupt is handed to an outgoing post channel as a core number and vector. A power-on reset pulses the core's reset line and marks the core running. A halt parks the core so that interrupts do not wake it. A resume marks the core running again.

The block holds one run/halt bit per core, and every core leaves system reset in the running state. A configuration input tells the block how many cores are fitted. A command aimed at a core outside that population is dropped completely. A reset command whose vector is not the power-on code does nothing except raise a one-cycle error flag. Every output is registered and appears on the clock edge that follows the sampled write.

Top module: `ipi_dispatcher`

## Requirements
- R1: Command word fields: the operation is bits 17:16 (0 interrupt, 1 reset, 2 halt, 3 resume), the target core is bits 12:8 and the vector is bits 5:0. No other bit affects the outcome.
- R2: A write whose target is greater than or equal to `cpuCount` (or to `NUM_CPU`) has no effect. It produces no post, no reset pulse and no error flag, and `runState` does not change.
- R3: An interrupt write raises `postValid` for exactly one cycle after the write edge, with `postCpu` set to the target and `postVec` set to the vector. It does not change `runState`, so a halted core stays halted.
- R4: A reset write whose vector equals `POR_VEC` (default 6'h01) pulses only the target's bit of `cpuReset` for one cycle. The target's `runState` bit is set in that same cycle.
- R5: A reset write with any other vector pulses `badResetVec` for one cycle. It has no other effect.
- R6: A halt write clears the target's `runState` bit and leaves every other bit unchanged.
- R7: A resume write sets the target's `runState` bit and leaves every other bit unchanged.
- R8: After reset, `runState` is all ones and `postValid`, `cpuReset` and `badResetVec` are zero.
- R9: In a cycle that follows no write, `postValid`, `cpuReset` and `badResetVec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command write strobe |
| wrData | input | 32 | Command word |
| cpuCount | input | 6 | Number of cores fitted |
| postValid | output | 1 | Interrupt post strobe |
| postCpu | output | 5 | Core to interrupt |
| postVec | output | 6 | Interrupt vector |
| runState | output | NUM_CPU | Run (1) or halt (0) per core |
| cpuReset | output | NUM_CPU | One-cycle reset pulse per core |
| badResetVec | output | 1 | Reset with unsupported vector |

## Verification
Random command words carry random bits outside the three fields, so the bench can tell whether a decoder looks at bits it should ignore. Targets are drawn from a range wider than the core population. This separates a correct boundary compare from an off-by-one and from a compare against the wrong limit. Reset vectors are weighted toward the power-on code so that both accepted and rejected resets occur often. Directed cases cover an interrupt sent to a halted core, a target exactly at the limit, a reset of a halted core, and a core count of zero.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_W  = 5;
  localparam int VEC_W = 6;
  localparam int CNT_W = ID_W + 1;
  localparam int OP_LSB  = 16;
  localparam int ID_LSB  = 8;
  localparam int VEC_LSB = 0;

  typedef enum logic [1:0] {
    OP_INTR   = 2'd0,
    OP_RESET  = 2'd1,
    OP_HALT   = 2'd2,
    OP_RESUME = 2'd3
  } op_e;

  typedef struct packed {
    logic             post;
    logic             por;
    logic             halt;
    logic             resume;
    logic             badVec;
    logic [ID_W-1:0]  cpu;
    logic [VEC_W-1:0] vec;
  } strobe_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int               NUM_CPU = 32,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  input  logic [CNT_W-1:0] cpuCount,
  output strobe_t          st
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_CPU);

  op_e              op;
  logic [ID_W-1:0]  tgt;
  logic [VEC_W-1:0] vec;
  logic             inRange;
  logic             go;

  always_comb begin
    op      = op_e'(wrData[OP_LSB +: 2]);
    tgt     = wrData[ID_LSB +: ID_W];
    vec     = wrData[VEC_LSB +: VEC_W];
    inRange = ({1'b0, tgt} < cpuCount) && ({1'b0, tgt} < MAX_CNT);
    go      = wrEn && inRange;
    st        = '0;
    st.cpu    = tgt;
    st.vec    = vec;
    st.post   = go && (op == OP_INTR);
    st.por    = go && (op == OP_RESET) && (vec == POR_VEC);
    st.badVec = go && (op == OP_RESET) && (vec != POR_VEC);
    st.halt   = go && (op == OP_HALT);
    st.resume = go && (op == OP_RESUME);
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.post, st.por, st.badVec, st.halt, st.resume}));

  // R2
  strobe_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.post || st.por || st.badVec || st.halt || st.resume) |->
      ({1'b0, st.cpu} < cpuCount));
endmodule

// File: rtl/ipi_dp.sv
module ipi_dp
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  output logic               postValid,
  output logic [ID_W-1:0]    postCpu,
  output logic [VEC_W-1:0]   postVec,
  output logic [NUM_CPU-1:0] runState,
  output logic [NUM_CPU-1:0] cpuReset,
  output logic               badResetVec
);
  logic [NUM_CPU-1:0] cpuSel;

  always_comb cpuSel = NUM_CPU'(1) << st.cpu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postValid   <= 1'b0;
      postCpu     <= '0;
      postVec     <= '0;
      runState    <= '1;
      cpuReset    <= '0;
      badResetVec <= 1'b0;
    end else begin
      postValid   <= st.post;
      badResetVec <= st.badVec;
      cpuReset    <= st.por ? cpuSel : '0;
      if (st.post) begin
        postCpu <= st.cpu;
        postVec <= st.vec;
      end
      if (st.por || st.resume) runState <= runState | cpuSel;
      else if (st.halt)        runState <= runState & ~cpuSel;
    end
  end

  // R4
  rst_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cpuReset));

  // R4
  rst_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((runState & cpuReset) == cpuReset));

  // R5
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    badResetVec |-> (!postValid && cpuReset == '0));

  // R6
  halt_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.halt |=> (runState & $past(cpuSel)) == '0);

  // R7
  resume_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.resume |=> (runState & $past(cpuSel)) == $past(cpuSel));
endmodule

// File: rtl/ipi_dispatcher.sv
module ipi_dispatcher
  import ipi_pkg::*;
#(
  parameter int               NUM_CPU = 32,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic [CNT_W-1:0]   cpuCount,
  output logic               postValid,
  output logic [ID_W-1:0]    postCpu,
  output logic [VEC_W-1:0]   postVec,
  output logic [NUM_CPU-1:0] runState,
  output logic [NUM_CPU-1:0] cpuReset,
  output logic               badResetVec
);
  strobe_t st;

  ipi_ctrl #(.NUM_CPU(NUM_CPU), .POR_VEC(POR_VEC)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cpuCount(cpuCount), .st(st)
  );

  ipi_dp #(.NUM_CPU(NUM_CPU)) i_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .postValid(postValid), .postCpu(postCpu), .postVec(postVec),
    .runState(runState), .cpuReset(cpuReset), .badResetVec(badResetVec)
  );

  // R2
  oor_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ({1'b0, wrData[ID_LSB +: ID_W]} >= cpuCount)) |=>
      (!postValid && cpuReset == '0 && !badResetVec && $stable(runState)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (!postValid && cpuReset == '0 && !badResetVec));
endmodule

// File: tb/test_ipi_dispatcher.sv
module test_ipi_dispatcher;
  localparam int NUM_CPU = 32;
  localparam logic [5:0] POR = 6'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [5:0] cpuCount = 6'd8;
  logic postValid, badResetVec;
  logic [4:0] postCpu;
  logic [5:0] postVec;
  logic [NUM_CPU-1:0] runState, cpuReset;

  int vecCnt = 0;
  int failCnt = 0;
  bit done = 0;
  logic [NUM_CPU-1:0] mRun;

  always #2.5 clk = ~clk;

  ipi_dispatcher #(.NUM_CPU(NUM_CPU), .POR_VEC(POR)) i_ipi_dispatcher (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cpuCount(cpuCount),
    .postValid(postValid), .postCpu(postCpu), .postVec(postVec),
    .runState(runState), .cpuReset(cpuReset), .badResetVec(badResetVec)
  );

  function automatic logic [31:0] mkWord(int op, int id, int vec, logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h0003_1F3F;
    w[17:16] = op[1:0];
    w[12:8]  = id[4:0];
    w[5:0]   = vec[5:0];
    return w;
  endfunction

  function automatic bit accepted(logic [31:0] w, logic [5:0] cnt);
    return ({1'b0, w[12:8]} < cnt) && (int'(w[12:8]) < NUM_CPU);
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle (write or idle) at negedge, check after the next posedge.
  task automatic apply(string tag, bit en, logic [31:0] w);
    bit acc;
    int op;
    int id;
    logic [NUM_CPU-1:0] sel;
    logic [NUM_CPU-1:0] expRst;
    bit expPost;
    bit expBad;
    @(negedge clk);
    wrEn = en;
    wrData = w;
    acc = en && accepted(w, cpuCount);
    op = int'(w[17:16]);
    id = int'(w[12:8]);
    sel = NUM_CPU'(1) << id;
    expPost = acc && op == 0;
    expBad  = acc && op == 1 && w[5:0] != POR;
    expRst  = (acc && op == 1 && w[5:0] == POR) ? sel : '0;
    if (acc && op == 1 && w[5:0] == POR) mRun |= sel;
    if (acc && op == 3) mRun |= sel;
    if (acc && op == 2) mRun &= ~sel;
    @(posedge clk);
    #1;
    vecCnt++;
    chk(tag, "postValid", postValid, expPost);
    if (expPost) begin
      chk(tag, "postCpu", postCpu, id);
      chk(tag, "postVec", postVec, w[5:0]);
    end
    chk(tag, "cpuReset", cpuReset, expRst);
    chk(tag, "badResetVec", badResetVec, expBad);
    chk(tag, "runState", runState, mRun);
    wrEn = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    mRun = '1;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    vecCnt++;
    chk("R8", "runState", runState, {NUM_CPU{1'b1}});
    chk("R8", "postValid", postValid, 0);
    chk("R8", "cpuReset", cpuReset, 0);
    chk("R8", "badResetVec", badResetVec, 0);
    @(negedge clk);
    rstN = 1'b1;

    // Directed corner cases
    apply("R9", 0, 32'hFFFF_FFFF);
    apply("R6", 1, mkWord(2, 3, 0, 0));
    apply("R3", 1, mkWord(0, 3, 6'h2A, 32'hFFFC_E0C0)); // halted core, junk bits (R1)
    apply("R7", 1, mkWord(3, 3, 0, 0));
    apply("R6", 1, mkWord(2, 5, 0, 0));
    apply("R4", 1, mkWord(1, 5, POR, 0));
    apply("R5", 1, mkWord(1, 6, 6'h02, 0));
    apply("R2", 1, mkWord(2, 8, 0, 0));   // target equal to cpuCount
    apply("R6", 1, mkWord(2, 7, 0, 0));   // last core in range
    apply("R2", 1, mkWord(1, 9, 6'h05, 0));
    apply("R9", 0, 0);
    cpuCount = 6'd0;
    apply("R2", 1, mkWord(0, 0, 6'h11, 0));
    cpuCount = 6'd32;
    apply("R3", 1, mkWord(0, 31, 6'h3F, 0));
    apply("R6", 1, mkWord(2, 31, 0, 0));
    apply("R4", 1, mkWord(1, 31, POR, 32'hFFFF_FFFF));

    // Constrained random
    for (int i = 0; i < 2000; i++) begin
      int op;
      int id;
      int vec;
      if (i % 500 == 0) cpuCount = 6'($urandom_range(1, 32));
      op  = $urandom_range(0, 3);
      id  = $urandom_range(0, 31);
      vec = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63)) : int'(POR);
      apply("R1", $urandom_range(0, 7) != 0, mkWord(op, id, vec, $urandom));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule